// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is the watchdog timer of a real-time clock. Software programs a single control byte. The byte holds a multiplier, a resolution selector and a steering bit. The timeout is the multiplier scaled by a power of four, counted in ticks of a 16 Hz enable input. Any access to the register, read or write, restarts the countdown. A read restarts it with the stored value and a write restarts it with the value just written. Software keeps the system alive by touching the register before the count runs out.

On expiry the block raises its timeout flag. The steering bit then decides the action. If it is clear, the block pulses an interrupt line. If it is set, the block pulses a system reset request, zeroes its own control byte and pulses a clear for the century bit kept elsewhere in the clock. After expiry the counter stays idle until the next access.

A parameter can place a prescaler in front of the counter, so that a faster tick enable can drive the block. The prescaler restarts on every access, which keeps the timeout exact.

Top module: `rtc_wdt`

## Requirements
- R1: After reset, `rd_data`, `flag`, `irq_pulse`, `rst_req` and `century_clr` are all 0, and no countdown runs until the register is accessed.
- R2: Control byte layout: bits 1:0 = resolution `r`, bits 6:2 = multiplier `m`, bit 7 = steering. The timeout is N = m * 4^r counted ticks. If the restart happens at clock edge E and a tick is present at every edge, the expiry pulse is high exactly in the cycle that follows edge E+N.
- R3: A write strobe stores `wr_data`, which appears on `rd_data` the next cycle, and restarts the countdown with the newly written value.
- R4: A read strobe restarts the countdown with the stored value and leaves `rd_data` unchanged. When read and write strobes coincide, the write value is stored and used.
- R5: A byte whose multiplier field is 0 gives a zero count and disables the watchdog, whatever its resolution or steering bits. Writing such a byte cancels a countdown already running, and no pulse follows.
- R6: Every restart clears `flag` by the next cycle. Expiry sets `flag` in the same cycle as the expiry pulse. `flag` then stays at 1 until the next restart.
- R7: On expiry with steering = 0, `irq_pulse` is high for exactly one cycle, while `rst_req` and `century_clr` stay low.
- R8: On expiry with steering = 1, `rst_req` and `century_clr` are high for exactly one cycle and `irq_pulse` stays low. The control byte reads 0 in the following cycle, unless a write lands in the pulse cycle.
- R9: After an expiry the counter stays idle, and no further pulse appears until the next restart.
- R10: A clock edge without `tick_in` does not advance the countdown. The count holds for as long as the tick is absent.
- R11: With `TICK_DIV` = D > 1, only every D-th tick advances the countdown, and a restart re-aligns the prescaler. The timeout therefore becomes D*N edges of continuous ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Tick enable (16 Hz time base, one clock wide) |
| wr_en | input | 1 | Write strobe for the control byte |
| rd_en | input | 1 | Read strobe for the control byte |
| wr_data | input | RES_W+MULT_W+1 | Byte to store |
| rd_data | output | RES_W+MULT_W+1 | Stored control byte |
| flag | output | 1 | Timeout flag |
| irq_pulse | output | 1 | One-cycle interrupt on expiry, steering clear |
| rst_req | output | 1 | One-cycle system reset request on expiry, steering set |
| century_clr | output | 1 | One-cycle clear for the century bit, issued with the reset request |

## Verification
The bench builds two instances that share one set of stimulus. The first uses the default 2-bit resolution, 5-bit multiplier and no prescaler, so every tick counts. Holding the tick high turns each timeout into an exact edge count, up to the longest one of 1984 edges. The second instance uses a divide-by-three prescaler, which exposes the re-alignment on restart and the tripled timeout. Gating the tick low exercises the hold behaviour without changing the parameters.

// File: rtl/rtc_wdt_pkg.sv
package rtc_wdt_pkg;

   typedef enum logic [1:0] {
      WDT_ACT_NONE = 2'd0,
      WDT_ACT_IRQ  = 2'd1,
      WDT_ACT_RST  = 2'd2
   } wdt_act_e;

   // counter width needed for the largest multiplier at the coarsest step
   function automatic int cnt_width(input int res_w, input int mult_w);
      return mult_w + 2 * ((1 << res_w) - 1);
   endfunction

endpackage

// File: rtl/rtc_wdt_cfg.sv
module rtc_wdt_cfg #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             auto_clr,
   output logic [REG_W-1:0] cfg_q
);

   // a software write outranks the self-clear after a reset request
   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (wr_en)
         cfg_q <= wr_data;
      else if (auto_clr)
         cfg_q <= '0;
   end

endmodule

// File: rtl/rtc_wdt_load.sv
module rtc_wdt_load #(
   parameter int RES_W  = 2,
   parameter int MULT_W = 5,
   parameter int CNT_W  = 11
) (
   input  logic [RES_W+MULT_W-1:0] field,
   output logic [CNT_W-1:0]        load
);

   localparam int NRES = 1 << RES_W;

   logic [RES_W-1:0]  res;
   logic [MULT_W-1:0] mult;
   logic [NRES-1:0][CNT_W-1:0] term;

   assign res  = field[RES_W-1:0];
   assign mult = field[RES_W +: MULT_W];

   // one shifted copy of the multiplier per resolution step, power of four
   for (genvar r = 0; r < NRES; r++) begin : g_step
      assign term[r] = (res == RES_W'(r)) ? (CNT_W'(mult) << (2 * r)) : '0;
   end

   always_comb begin
      load = '0;
      for (int i = 0; i < NRES; i++)
         load = load | term[i];
   end

endmodule

// File: rtl/rtc_wdt_presc.sv
module rtc_wdt_presc #(
   parameter int TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick_in,
   output logic tick_out
);

   if (TICK_DIV == 1) begin : g_pass
      logic unused_presc;
      assign unused_presc = ^{clk, rst_n, restart};
      assign tick_out     = tick_in;
   end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pc;

      always_ff @(posedge clk) begin
         if (!rst_n)
            pc <= '0;
         else if (restart)
            pc <= '0;
         else if (tick_in)
            pc <= (pc == LAST) ? '0 : pc + 1'b1;
      end

      assign tick_out = tick_in && (pc == LAST) && !restart;
   end

endmodule

// File: rtl/rtc_wdt_cnt.sv
module rtc_wdt_cnt #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick,
   input  logic [CNT_W-1:0] load,
   input  logic             tick,
   output logic             fire_now,
   output logic             fire_q
);

   logic [CNT_W-1:0] cnt;
   logic             armed;

   // expiry needs a tick on the last unit; a restart in that cycle wins
   assign fire_now = armed && tick && !kick && (cnt == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (kick) begin
         cnt   <= load;
         armed <= (load != '0);
      end else if (armed && tick) begin
         if (cnt == CNT_W'(1)) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         fire_q <= 1'b0;
      else
         fire_q <= fire_now;
   end

endmodule

// File: rtl/rtc_wdt.sv
module rtc_wdt
   import rtc_wdt_pkg::*;
#(
   parameter int RES_W    = 2,
   parameter int MULT_W   = 5,
   parameter int TICK_DIV = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_in,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [RES_W+MULT_W:0]     wr_data,
   output logic [RES_W+MULT_W:0]     rd_data,
   output logic                      flag,
   output logic                      irq_pulse,
   output logic                      rst_req,
   output logic                      century_clr
);

   localparam int FIELD_W = RES_W + MULT_W;
   localparam int REG_W   = FIELD_W + 1;
   localparam int CNT_W   = cnt_width(RES_W, MULT_W);

   if (RES_W < 1 || RES_W > 3) begin : g_bad_res
      $error("rtc_wdt: RES_W must lie in 1..3");
   end
   if (MULT_W < 1 || MULT_W > 16) begin : g_bad_mult
      $error("rtc_wdt: MULT_W must lie in 1..16");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("rtc_wdt: TICK_DIV must be at least 1");
   end

   logic               kick;
   logic [REG_W-1:0]   cfg_q;
   logic [FIELD_W-1:0] load_src;
   logic [CNT_W-1:0]   load;
   logic               tick;
   logic               fire_now;
   logic               fire_q;
   logic               flag_q;
   wdt_act_e           act;

   assign kick     = wr_en | rd_en;
   assign load_src = wr_en ? wr_data[FIELD_W-1:0] : cfg_q[FIELD_W-1:0];

   rtc_wdt_cfg #(.REG_W(REG_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .auto_clr (act == WDT_ACT_RST),
      .cfg_q    (cfg_q)
   );

   rtc_wdt_load #(.RES_W(RES_W), .MULT_W(MULT_W), .CNT_W(CNT_W)) u_load (
      .field (load_src),
      .load  (load)
   );

   rtc_wdt_presc #(.TICK_DIV(TICK_DIV)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (kick),
      .tick_in  (tick_in),
      .tick_out (tick)
   );

   rtc_wdt_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .kick     (kick),
      .load     (load),
      .tick     (tick),
      .fire_now (fire_now),
      .fire_q   (fire_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (kick)
         flag_q <= 1'b0;
      else if (fire_now)
         flag_q <= 1'b1;
   end

   always_comb begin
      if (!fire_q)
         act = WDT_ACT_NONE;
      else if (cfg_q[REG_W-1])
         act = WDT_ACT_RST;
      else
         act = WDT_ACT_IRQ;
   end

   assign rd_data     = cfg_q;
   assign flag        = flag_q;
   assign irq_pulse   = (act == WDT_ACT_IRQ);
   assign rst_req     = (act == WDT_ACT_RST);
   assign century_clr = (act == WDT_ACT_RST);

endmodule

// File: rtl/rtc_wdt_chk.sv
module rtc_wdt_chk #(
   parameter int RES_W  = 2,
   parameter int MULT_W = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  tick_in,
   input logic                  wr_en,
   input logic                  rd_en,
   input logic [RES_W+MULT_W:0] wr_data,
   input logic [RES_W+MULT_W:0] rd_data,
   input logic                  flag,
   input logic                  irq_pulse,
   input logic                  rst_req
);

   // R7
   steer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && irq_pulse));

   // R7
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   // R8
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R8
   rst_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !wr_en) |=> (rd_data == '0));

   // R3
   write_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == $past(wr_data)));

   // R4
   read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && !rst_req) |=> $stable(rd_data));

   // R6
   kick_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || rd_en) |=> !flag);

   // R6
   flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (rst_req || irq_pulse));

   // R5
   zero_mult_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_data[RES_W +: MULT_W] == '0)) |=> !(rst_req || irq_pulse));

   // R10
   no_tick_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_in |=> !(rst_req || irq_pulse));

endmodule

bind rtc_wdt rtc_wdt_chk #(.RES_W(RES_W), .MULT_W(MULT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_in   (tick_in),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .flag      (flag),
   .irq_pulse (irq_pulse),
   .rst_req   (rst_req)
);

// File: tb/rtc_wdt_test.sv
module rtc_wdt_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick_in;
   logic       wr_en;
   logic       rd_en;
   logic [7:0] wr_data;

   logic [7:0] rd_data;
   logic       flag, irq_pulse, rst_req, century_clr;
   logic [7:0] d_rd_data;
   logic       d_flag, d_irq, d_rst, d_cent;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rtc_wdt uut (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .flag(flag), .irq_pulse(irq_pulse),
      .rst_req(rst_req), .century_clr(century_clr)
   );

   rtc_wdt #(.TICK_DIV(3)) uut_div (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(d_rd_data), .flag(d_flag), .irq_pulse(d_irq),
      .rst_req(d_rst), .century_clr(d_cent)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int span(input logic [7:0] v);
      return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
   endfunction

   task automatic wr(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic rd();
      rd_en = 1'b1;
      step(1);
      rd_en = 1'b0;
   endtask

   // called one negedge after the restart edge
   task automatic expect_expiry(input string req, input int n, input bit to_rst);
      step(n - 1);
      chk({req, " pulse early"}, int'(irq_pulse | rst_req), 0);
      chk({req, " flag early"}, int'(flag), 0);
      step(1);
      chk({req, " irq at expiry"}, int'(irq_pulse), to_rst ? 0 : 1);
      chk({req, " rst at expiry"}, int'(rst_req), to_rst ? 1 : 0);
      chk({req, " century at expiry"}, int'(century_clr), to_rst ? 1 : 0);
      chk({req, " flag at expiry"}, int'(flag), 1);
      step(1);
      chk({req, " pulse width"}, int'(irq_pulse | rst_req | century_clr), 0);
   endtask

   task automatic quiet(input string req, input int n);
      int bad = 0;
      repeat (n) begin
         step(1);
         if (irq_pulse || rst_req) bad++;
      end
      chk({req, " unexpected pulses"}, bad, 0);
   endtask

   task automatic t_reset();
      chk("R1 rd_data", int'(rd_data), 0);
      chk("R1 flag", int'(flag), 0);
      chk("R1 outputs", int'(irq_pulse | rst_req | century_clr), 0);
      quiet("R1 idle", 30);
   endtask

   task automatic t_irq();
      wr(8'h0C);
      chk("R3 readback", int'(rd_data), 8'h0C);
      expect_expiry("R7", 3, 1'b0);
      quiet("R9", 100);
      chk("R6 flag held", int'(flag), 1);
   endtask

   task automatic t_resolutions();
      logic [7:0] vals [4] = '{8'h09, 8'h06, 8'h07, 8'h7D};
      foreach (vals[i]) begin
         wr(vals[i]);
         expect_expiry("R2", span(vals[i]), 1'b0);
      end
   endtask

   task automatic t_reset_path();
      wr(8'h88);
      expect_expiry("R8", 2, 1'b1);
      chk("R8 cfg cleared", int'(rd_data), 0);
      quiet("R9 after reset request", 60);
   endtask

   task automatic t_read_kick();
      wr(8'h10);
      step(2);
      rd();
      chk("R6 flag cleared by read", int'(flag), 0);
      chk("R4 cfg kept", int'(rd_data), 8'h10);
      expect_expiry("R4", 4, 1'b0);
      rd();
      chk("R6 flag cleared after expiry", int'(flag), 0);
      expect_expiry("R4 second", 4, 1'b0);
   endtask

   task automatic t_disable();
      wr(8'h14);
      step(2);
      wr(8'h00);
      quiet("R5 zero byte", 80);
      wr(8'h83);
      quiet("R5 zero multiplier", 80);
   endtask

   task automatic t_hold();
      tick_in = 1'b0;
      wr(8'h08);
      quiet("R10 no tick", 40);
      tick_in = 1'b1;
      expect_expiry("R10 resume", 2, 1'b0);
   endtask

   task automatic t_both();
      wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h04;
      step(1);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R4 write wins", int'(rd_data), 8'h04);
      expect_expiry("R4 collide", 1, 1'b0);
   endtask

   task automatic t_div();
      wr(8'h08);
      step(5);
      chk("R11 divided early", int'(d_irq), 0);
      step(1);
      chk("R11 divided expiry", int'(d_irq), 1);
      chk("R11 divided flag", int'(d_flag), 1);
      step(1);
      chk("R11 divided width", int'(d_irq), 0);
   endtask

   task automatic t_max();
      wr(8'h7F);
      expect_expiry("R2 longest", span(8'h7F), 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; tick_in = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
      step(5);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_irq();
      t_resolutions();
      t_reset_path();
      t_read_kick();
      t_disable();
      t_hold();
      t_both();
      t_div();
      t_max();
      step(3);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule